// File: doc/BRIEF.md
# Embedded DRAM March-Test Self-Test Sequencer

This block is a built-in self-test controller for a DRAM-cell memory that is reached through a plain synchronous SRAM-like port. One `start` pulse runs two fixed phases, one after the other. The first phase is an extended March C- pass that uses a solid background and steps the row index fastest. The second phase is a MATS pass that uses a checkerboard background and steps the column index fastest. Self-refresh handshakes and retention waits sit between the elements of the second phase. Self-refresh steps are also placed inside the first phase, and a configuration bit can remove them.

Backgrounds are defined as physical cell values. Before a word goes onto the data bus, the block converts it to the logical value. The conversion accounts for cells that hang on the bit-line-bar, for the two interleaved words that share a word-line, and for bit-line twists at configurable row positions. The same converted value is the expected value for reads. The 32-bit word is made of two 16-bit halves that come from separate arrays.

A read returns its data one cycle after it is issued. The first mismatch is recorded, together with its phase, step, address, expected word and actual word. The fail flag then stays set until the next run. By default the run carries on to the end; when stop-on-fail is set, it stops at the first mismatch.

Top module: `edram_march_bist`

## Requirements
- R1: Phase 0 runs these steps, numbered 0 to 7: 0 up(w a); 1 up(r a, w b, r b); 2 self-refresh; 3 up(r b, w a); 4 down(r a, w b); 5 down(r b, w a); 6 self-refresh; 7 down(r a). This is 11 accesses per address, issued one per cycle with no gap inside a step.
- R2: `mem_addr` = row*COLS + col, where COLS = 2**COL_W. Phase 0 steps the row index fastest. "up" starts at the lowest address and "down" starts at the highest.
- R3: Phase 1 runs these steps, numbered 0 to 6: 0 up(w a); 1 self-refresh; 2 retention wait; 3 up(r a, w b); 4 self-refresh; 5 retention wait; 6 down(r b). Phase 1 steps the column index fastest.
- R4: A retention wait lasts max(`delay_cycles`,1) cycles. The number of cycles with neither `sr_req` nor an access, counted from the fall of a phase-1 `sr_req` to the next access, is max(`delay_cycles`,1)+2.
- R5: `sr_req` stays high until `sr_ack` is seen. No access is issued while `sr_req` is high. A run with `skip_p1_sr`=0 raises `sr_req` four times.
- R6: With `skip_p1_sr`=1, both phase-0 self-refresh steps are left out, so `sr_req` rises only twice per run.
- R7: The bus value is the physical value XOR a polarity mask. Mask bit i = ((i mod 16) mod 2) XOR (col mod 2) XOR (the parity of the number of enabled twists k for which row >= `twist_pos[k*ROW_W +: ROW_W]`).
- R8: The physical background in phase 0 is a = all 0s and b = all 1s. In phase 1, physical bit i = (row + (i mod 16)*COLS + col + inv) mod 2, where inv is 1 for b.
- R9: Read data is compared in the cycle after `mem_re` against the value that R7 and R8 give. A fault-free memory leaves `fail` at 0.
- R10: The first mismatch sets `fail` and stores `diag_phase`, `diag_elem`, `diag_addr`, `diag_exp` and `diag_act`. All of these hold until the next accepted `start`.
- R11: With `stop_on_fail`=0, the run completes every access. With `stop_on_fail`=1, the run ends at the first mismatch, `done` pulses, and no further access is issued.
- R12: After reset, `busy`, `done`, `fail`, `sr_req`, `mem_we` and `mem_re` are all 0. `done` is a one-cycle pulse that ends a run, and `busy` is low after it. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| skip_p1_sr | input | 1 | Leave out the phase-0 self-refresh steps |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| delay_cycles | input | DLY_W | Retention wait length in cycles |
| twist_pos | input | NUM_TWIST*ROW_W | Row position of each bit-line twist |
| twist_en | input | NUM_TWIST | Enable for each twist |
| mem_addr | output | ROW_W+COL_W | Word address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 2*HALF_W | Write data (logical) |
| mem_rdata | input | 2*HALF_W | Read data, one cycle after mem_re |
| sr_req | output | 1 | Self-refresh request |
| sr_ack | input | 1 | Self-refresh acknowledge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| diag_phase | output | 1 | Phase of first mismatch |
| diag_elem | output | 4 | Step index of first mismatch |
| diag_addr | output | ROW_W+COL_W | Address of first mismatch |
| diag_exp | output | 2*HALF_W | Expected word at first mismatch |
| diag_act | output | 2*HALF_W | Read word at first mismatch |

## Verification
Some properties are checked on every cycle. Inside a step, the address holds until the last operation at that address, and then it moves. `sr_req` cannot drop before the acknowledge arrives. `done` lasts one cycle. The fail flag and the captured diagnosis hold once set, and the capture takes the word that was read. Other behaviour can only be shown by the bench's scenarios, where every access is compared in order against an independently built trace: step ordering, row-fast versus column-fast walks, the polarity mask under random twist settings, the length of the retention gap, the removal of the self-refresh steps, and the diagnosis and halt behaviour under an injected read fault.

// File: rtl/edram_bist_pkg.sv
package edram_bist_pkg;

  localparam int STEP_W = 4;

  typedef enum logic [1:0] {
    K_OPS = 2'd0,
    K_SR  = 2'd1,
    K_DLY = 2'd2,
    K_END = 2'd3
  } step_kind_e;

  // One step of a phase: kind, walk direction, operation count and per-slot
  // read flag / complement-background flag (slot j uses bit j).
  typedef struct packed {
    step_kind_e  kind;
    logic        down;
    logic [1:0]  nops;
    logic [3:0]  rd;
    logic [3:0]  inv;
  } step_t;

  function automatic step_t mk_step(step_kind_e k, logic dn, logic [1:0] n,
                                    logic [3:0] rd, logic [3:0] inv);
    step_t s;
    s.kind = k;
    s.down = dn;
    s.nops = n;
    s.rd   = rd;
    s.inv  = inv;
    return s;
  endfunction

  // Step table for both phases; phase 0 = solid, phase 1 = checkerboard.
  function automatic step_t step_lookup(logic phase, logic [STEP_W-1:0] idx);
    step_t s;
    s = mk_step(K_END, 1'b0, 2'd1, 4'b0000, 4'b0000);
    if (!phase) begin
      case (idx)
        4'd0: s = mk_step(K_OPS, 1'b0, 2'd1, 4'b0000, 4'b0000); // w a
        4'd1: s = mk_step(K_OPS, 1'b0, 2'd3, 4'b0101, 4'b0110); // r a, w b, r b
        4'd2: s = mk_step(K_SR,  1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd3: s = mk_step(K_OPS, 1'b0, 2'd2, 4'b0001, 4'b0001); // r b, w a
        4'd4: s = mk_step(K_OPS, 1'b1, 2'd2, 4'b0001, 4'b0010); // r a, w b
        4'd5: s = mk_step(K_OPS, 1'b1, 2'd2, 4'b0001, 4'b0001); // r b, w a
        4'd6: s = mk_step(K_SR,  1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd7: s = mk_step(K_OPS, 1'b1, 2'd1, 4'b0001, 4'b0000); // r a
        default: ;
      endcase
    end else begin
      case (idx)
        4'd0: s = mk_step(K_OPS, 1'b0, 2'd1, 4'b0000, 4'b0000); // w a
        4'd1: s = mk_step(K_SR,  1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd2: s = mk_step(K_DLY, 1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd3: s = mk_step(K_OPS, 1'b0, 2'd2, 4'b0001, 4'b0010); // r a, w b
        4'd4: s = mk_step(K_SR,  1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd5: s = mk_step(K_DLY, 1'b0, 2'd1, 4'b0000, 4'b0000);
        4'd6: s = mk_step(K_OPS, 1'b1, 2'd1, 4'b0001, 4'b0001); // r b
        default: ;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/bist_datagen.sv
module bist_datagen #(
  parameter int ROW_W     = 3,
  parameter int COL_W     = 2,
  parameter int HALF_W    = 16,
  parameter int NUM_TWIST = 2
) (
  input  logic [ROW_W-1:0]           row,
  input  logic [COL_W-1:0]           col,
  input  logic                       phase,
  input  logic                       inv,
  input  logic [NUM_TWIST*ROW_W-1:0] twist_pos,
  input  logic [NUM_TWIST-1:0]       twist_en,
  output logic [2*HALF_W-1:0]        data
);
  localparam int DATA_W = 2 * HALF_W;
  localparam int COLS   = 1 << COL_W;

  // Odd count of passed twists flips the whole column polarity.
  function automatic logic twist_parity(input logic [ROW_W-1:0] r,
                                        input logic [NUM_TWIST*ROW_W-1:0] pos,
                                        input logic [NUM_TWIST-1:0] en);
    logic p;
    p = 1'b0;
    for (int k = 0; k < NUM_TWIST; k++)
      if (en[k] && (r >= pos[k*ROW_W +: ROW_W])) p = ~p;
    return p;
  endfunction

  // Bit-line-bar cells: odd pair within the half, shifted by word interleave.
  function automatic logic [DATA_W-1:0] polarity_mask(input logic [COL_W-1:0] c,
                                                      input logic flip);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++)
      m[i] = (((i % HALF_W) % 2) == 1) ^ c[0] ^ flip;
    return m;
  endfunction

  // Physical background value of every cell of the addressed word.
  function automatic logic [DATA_W-1:0] phys_bg(input logic ph,
                                                input logic [ROW_W-1:0] r,
                                                input logic [COL_W-1:0] c,
                                                input logic b);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) begin
      if (!ph) v[i] = b;
      else     v[i] = r[0] ^ ((((i % HALF_W) * COLS) % 2) == 1) ^ c[0] ^ b;
    end
    return v;
  endfunction

  logic             flip;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] phys;

  assign flip = twist_parity(row, twist_pos, twist_en);
  assign mask = polarity_mask(col, flip);
  assign phys = phys_bg(phase, row, col, inv);
  assign data = phys ^ mask;

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import edram_bist_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 2,
  parameter int DLY_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   skip_p1_sr,
  input  logic [DLY_W-1:0]       delay_cycles,
  input  logic                   sr_ack,
  input  logic                   halt,
  output logic                   op_valid,
  output logic                   op_rd,
  output logic                   op_inv,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   phase,
  output logic [STEP_W-1:0]      elem,
  output logic                   sr_req,
  output logic                   done,
  output logic                   busy,
  output logic                   clr
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_OPS, S_SR, S_DLY, S_DONE} st_e;

  st_e               state;
  logic [ADDR_W-1:0] cnt;
  logic [1:0]        opi;
  logic [DLY_W-1:0]  dly;
  step_t             cur;
  logic              last_op;
  logic              last_addr;

  assign cur       = step_lookup(phase, elem);
  assign last_op   = (opi == cur.nops - 2'd1);
  assign last_addr = cur.down ? (cnt == '0) : (cnt == LAST);

  // Phase 0 walks rows fastest, phase 1 walks columns fastest.
  assign row = phase ? cnt[ADDR_W-1:COL_W] : cnt[ROW_W-1:0];
  assign col = phase ? cnt[COL_W-1:0]      : cnt[ADDR_W-1:ROW_W];

  assign op_valid = (state == S_OPS);
  assign op_rd    = cur.rd[opi];
  assign op_inv   = cur.inv[opi];
  assign sr_req   = (state == S_SR);
  assign done     = (state == S_DONE);
  assign busy     = (state != S_IDLE) && (state != S_DONE);
  assign clr      = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= 1'b0;
      elem  <= '0;
      cnt   <= '0;
      opi   <= '0;
      dly   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_LOAD;
          phase <= 1'b0;
          elem  <= '0;
        end
        S_LOAD: begin
          case (cur.kind)
            K_OPS: begin
              cnt   <= cur.down ? LAST : '0;
              opi   <= '0;
              state <= S_OPS;
            end
            K_SR: begin
              if (!phase && skip_p1_sr) elem <= elem + STEP_W'(1);
              else                      state <= S_SR;
            end
            K_DLY: begin
              dly   <= (delay_cycles == '0) ? DLY_W'(1) : delay_cycles;
              state <= S_DLY;
            end
            default: begin
              if (!phase) begin
                phase <= 1'b1;
                elem  <= '0;
              end else begin
                state <= S_DONE;
              end
            end
          endcase
        end
        S_OPS: begin
          if (!last_op) begin
            opi <= opi + 2'd1;
          end else begin
            opi <= '0;
            if (last_addr) begin
              elem  <= elem + STEP_W'(1);
              state <= S_LOAD;
            end else begin
              cnt <= cur.down ? cnt - 1'b1 : cnt + 1'b1;
            end
          end
        end
        S_SR: if (sr_ack) begin
          elem  <= elem + STEP_W'(1);
          state <= S_LOAD;
        end
        S_DLY: begin
          if (dly <= DLY_W'(1)) begin
            elem  <= elem + STEP_W'(1);
            state <= S_LOAD;
          end else begin
            dly <= dly - DLY_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
      if (halt && (state != S_IDLE) && (state != S_DONE)) state <= S_DONE;
    end
  end

  // R1: the address holds for every operation of a step at one location
  assert_op_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !last_op && !halt) |=> (op_valid && $stable(cnt)));

  // R2: after the last operation at a non-final address the walk moves on
  assert_addr_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && last_op && !last_addr && !halt) |=> (op_valid && (cnt != $past(cnt))));

  // R5: a pending self-refresh request is not withdrawn before its acknowledge
  assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_req && !sr_ack && !halt) |=> sr_req);

  // R12: done is a single-cycle pulse that leaves the block idle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

// File: rtl/bist_cmp.sv
module bist_cmp #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] exp_in,
  input  logic              phase_in,
  input  logic [STEP_W-1:0] elem_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] rdata,
  output logic              first_hit,
  output logic              fail,
  output logic              diag_phase,
  output logic [STEP_W-1:0] diag_elem,
  output logic [ADDR_W-1:0] diag_addr,
  output logic [DATA_W-1:0] diag_exp,
  output logic [DATA_W-1:0] diag_act
);
  // One-stage expectation pipeline matches the one-cycle read latency.
  logic              pend;
  logic [DATA_W-1:0] exp_q;
  logic              phase_q;
  logic [STEP_W-1:0] elem_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mismatch;

  assign mismatch  = pend && (rdata != exp_q);
  assign first_hit = mismatch && !fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      exp_q   <= '0;
      phase_q <= 1'b0;
      elem_q  <= '0;
      addr_q  <= '0;
    end else begin
      pend    <= rd_issue;
      exp_q   <= exp_in;
      phase_q <= phase_in;
      elem_q  <= elem_in;
      addr_q  <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fail       <= 1'b0;
      diag_phase <= 1'b0;
      diag_elem  <= '0;
      diag_addr  <= '0;
      diag_exp   <= '0;
      diag_act   <= '0;
    end else if (first_hit) begin
      fail       <= 1'b1;
      diag_phase <= phase_q;
      diag_elem  <= elem_q;
      diag_addr  <= addr_q;
      diag_exp   <= exp_q;
      diag_act   <= rdata;
    end
  end

  // R10: fail is sticky until a new run clears it
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);

  // R10: captured diagnosis does not move after the first mismatch
  assert_diag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> ($stable(diag_addr) && $stable(diag_act) && $stable(diag_elem)));

  // R9: the capture takes the read word of the failing cycle
  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (first_hit && !clr) |=> (fail && (diag_act == $past(rdata))));

endmodule

// File: rtl/edram_march_bist.sv
module edram_march_bist #(
  parameter int ROW_W     = 3,
  parameter int COL_W     = 2,
  parameter int HALF_W    = 16,
  parameter int NUM_TWIST = 2,
  parameter int DLY_W     = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic                            skip_p1_sr,
  input  logic                            stop_on_fail,
  input  logic [DLY_W-1:0]                delay_cycles,
  input  logic [NUM_TWIST*ROW_W-1:0]      twist_pos,
  input  logic [NUM_TWIST-1:0]            twist_en,
  output logic [ROW_W+COL_W-1:0]          mem_addr,
  output logic                            mem_we,
  output logic                            mem_re,
  output logic [2*HALF_W-1:0]             mem_wdata,
  input  logic [2*HALF_W-1:0]             mem_rdata,
  output logic                            sr_req,
  input  logic                            sr_ack,
  output logic                            busy,
  output logic                            done,
  output logic                            fail,
  output logic                            diag_phase,
  output logic [3:0]                      diag_elem,
  output logic [ROW_W+COL_W-1:0]          diag_addr,
  output logic [2*HALF_W-1:0]             diag_exp,
  output logic [2*HALF_W-1:0]             diag_act
);
  import edram_bist_pkg::*;

  localparam int DATA_W = 2 * HALF_W;
  localparam int ADDR_W = ROW_W + COL_W;

  logic              op_valid;
  logic              op_rd;
  logic              op_inv;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              phase;
  logic [STEP_W-1:0] elem;
  logic              clr;
  logic              first_hit;
  logic              halt;
  logic [DATA_W-1:0] word;

  assign halt = first_hit && stop_on_fail;

  bist_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_p1_sr(skip_p1_sr),
    .delay_cycles(delay_cycles), .sr_ack(sr_ack), .halt(halt),
    .op_valid(op_valid), .op_rd(op_rd), .op_inv(op_inv), .row(row), .col(col),
    .phase(phase), .elem(elem), .sr_req(sr_req), .done(done), .busy(busy), .clr(clr)
  );

  bist_datagen #(.ROW_W(ROW_W), .COL_W(COL_W), .HALF_W(HALF_W), .NUM_TWIST(NUM_TWIST)) u_dgen (
    .row(row), .col(col), .phase(phase), .inv(op_inv),
    .twist_pos(twist_pos), .twist_en(twist_en), .data(word)
  );

  assign mem_addr  = {row, col};
  assign mem_we    = op_valid && !op_rd;
  assign mem_re    = op_valid && op_rd;
  assign mem_wdata = mem_we ? word : '0;

  bist_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_issue(mem_re), .exp_in(word),
    .phase_in(phase), .elem_in(elem), .addr_in(mem_addr), .rdata(mem_rdata),
    .first_hit(first_hit), .fail(fail), .diag_phase(diag_phase),
    .diag_elem(diag_elem), .diag_addr(diag_addr), .diag_exp(diag_exp),
    .diag_act(diag_act)
  );

  // R11: once halted by stop-on-fail, no access follows the end pulse
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_on_fail && fail) |=> !(mem_we || mem_re));

endmodule

// File: tb/edram_march_bist_bench.sv
module edram_march_bist_bench;
  localparam int ROWS = 8;
  localparam int COLS = 4;
  localparam int NW   = ROWS * COLS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        skip_p1_sr = 1'b0;
  logic        stop_on_fail = 1'b0;
  logic [19:0] delay_cycles = 20'd4;
  logic [5:0]  twist_pos = '0;
  logic [1:0]  twist_en = '0;
  logic [4:0]  mem_addr;
  logic        mem_we, mem_re;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        sr_req;
  logic        sr_ack = 1'b0;
  logic        busy, done, fail, diag_phase;
  logic [3:0]  diag_elem;
  logic [4:0]  diag_addr;
  logic [31:0] diag_exp, diag_act;

  always #10 clk = ~clk;

  edram_march_bist u_edram_march_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_p1_sr(skip_p1_sr),
    .stop_on_fail(stop_on_fail), .delay_cycles(delay_cycles), .twist_pos(twist_pos),
    .twist_en(twist_en), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sr_req(sr_req), .sr_ack(sr_ack),
    .busy(busy), .done(done), .fail(fail), .diag_phase(diag_phase),
    .diag_elem(diag_elem), .diag_addr(diag_addr), .diag_exp(diag_exp), .diag_act(diag_act)
  );

  // memory model with optional read fault
  logic [31:0] mem [0:NW-1];
  logic        flt_on = 1'b0;
  logic [4:0]  flt_addr = '0;
  logic [31:0] flt_mask = '0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr] ^ ((flt_on && mem_addr == flt_addr) ? flt_mask : 32'h0);
  end

  // self-refresh responder with random acknowledge latency
  int ack_wait = 0;
  always @(negedge clk) begin
    if (!sr_req) begin
      sr_ack = 1'b0;
      ack_wait = $urandom % 4;
    end else if (!sr_ack) begin
      if (ack_wait == 0) sr_ack = 1'b1;
      else ack_wait--;
    end
  end

  // expected access trace
  logic        tr_we   [0:511];
  logic [4:0]  tr_addr [0:511];
  logic [31:0] tr_data [0:511];
  int          tr_ph   [0:511];
  int          tr_el   [0:511];
  int          n_exp = 0;
  int          tw_p [2];
  int          tw_e [2];

  function automatic logic [31:0] bgen(int ph, int r, int c, int inv);
    logic [31:0] v;
    int flips = 0;
    for (int k = 0; k < 2; k++) if (tw_e[k] != 0 && r >= tw_p[k]) flips++;
    for (int i = 0; i < 32; i++) begin
      int pv = (ph == 0) ? inv : (r + (i % 16) * COLS + c + inv) % 2;
      int pol = ((i % 16) + c + flips) % 2;
      v[i] = ((pv + pol) % 2) == 1;
    end
    return v;
  endfunction

  // op codes: 0 w a, 1 w b, 2 r a, 3 r b
  task automatic add_elem(int ph, int el, int down, int n, int o0, int o1, int o2);
    for (int s = 0; s < NW; s++) begin
      int k = (down != 0) ? NW - 1 - s : s;
      int r, c;
      if (ph == 0) begin r = k % ROWS; c = k / ROWS; end
      else begin c = k % COLS; r = k / COLS; end
      for (int j = 0; j < n; j++) begin
        int code = (j == 0) ? o0 : ((j == 1) ? o1 : o2);
        tr_we[n_exp]   = (code < 2);
        tr_addr[n_exp] = 5'(r * COLS + c);
        tr_data[n_exp] = bgen(ph, r, c, code % 2);
        tr_ph[n_exp]   = ph;
        tr_el[n_exp]   = el;
        n_exp++;
      end
    end
  endtask

  task automatic build_trace();
    n_exp = 0;
    add_elem(0, 0, 0, 1, 0, 0, 0);
    add_elem(0, 1, 0, 3, 2, 1, 3);
    add_elem(0, 3, 0, 2, 3, 0, 0);
    add_elem(0, 4, 1, 2, 2, 1, 0);
    add_elem(0, 5, 1, 2, 3, 0, 0);
    add_elem(0, 7, 1, 1, 2, 0, 0);
    add_elem(1, 0, 0, 1, 0, 0, 0);
    add_elem(1, 3, 0, 2, 2, 1, 0);
    add_elem(1, 6, 1, 1, 3, 0, 0);
  endtask

  // port monitor
  logic        new_run = 1'b0;
  logic        seen_run = 1'b0;
  int          mon_i = 0, trace_err = 0, n_sr = 0, n_done = 0, late_acc = 0;
  int          gap = 0, last_gap = 0, sr_in_req = 0, sr_viol = 0;
  int          err_idx = -1;
  logic [31:0] err_act = '0;
  logic        sr_prev = 1'b0, gap_run = 1'b0, post_done = 1'b0;
  always @(negedge clk) begin
    if (new_run != seen_run) begin
      seen_run = new_run;
      mon_i = 0; trace_err = 0; n_sr = 0; n_done = 0; late_acc = 0;
      gap = 0; last_gap = 0; sr_viol = 0; err_idx = -1;
      gap_run = 1'b0; post_done = 1'b0;
    end
    if (rst_n) begin
      if (sr_req && !sr_prev) n_sr++;
      if (sr_req && (mem_we || mem_re)) sr_viol++;
      if (mem_we || mem_re) begin
        if (post_done) late_acc++;
        if (mon_i >= n_exp || mem_we !== tr_we[mon_i] || mem_addr !== tr_addr[mon_i] ||
            (mem_we && mem_wdata !== tr_data[mon_i])) begin
          if (trace_err == 0) begin err_idx = mon_i; err_act = {mem_we, 26'h0, mem_addr} ^ 32'h0 | (mem_we ? mem_wdata : 32'h0); end
          trace_err++;
        end
        mon_i++;
        if (gap_run) last_gap = gap;
        gap_run = 1'b0;
      end else if (sr_req) begin
        gap_run = 1'b1;
        gap = 0;
      end else if (gap_run) begin
        gap++;
      end
      if (done) begin n_done++; post_done = 1'b1; end
      sr_prev = sr_req;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive_start();
    @(posedge clk); #5 start = 1'b1;
    @(posedge clk); #5 start = 1'b0;
  endtask

  task automatic run_bist(input bit extra_start);
    int cyc = 0;
    new_run = ~new_run;
    drive_start();
    while (n_done == 0 && cyc < 20000) begin
      @(posedge clk);
      cyc++;
      if (extra_start && cyc == 60) begin
        #5 start = 1'b1;
        @(posedge clk); #5 start = 1'b0;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(int p0, int p1, int e0, int e1);
    tw_p[0] = p0; tw_p[1] = p1; tw_e[0] = e0; tw_e[1] = e1;
    @(posedge clk); #5;
    twist_pos = {3'(p1), 3'(p0)};
    twist_en  = {1'(e1), 1'(e0)};
  endtask

  task automatic check_clean(input string tag, input int dly, input int n_sr_exp);
    chk(trace_err == 0, "R7", {tag, " access trace (polarity/background R8)"}, 64'(err_act),
        (err_idx >= 0) ? 64'(tr_data[err_idx]) : 64'h0);
    chk(mon_i == n_exp, "R1", {tag, " access count phase0+phase1 (R3)"}, 64'(mon_i), 64'(n_exp));
    chk(n_sr == n_sr_exp, (n_sr_exp == 4) ? "R5" : "R6", {tag, " self-refresh requests"}, 64'(n_sr), 64'(n_sr_exp));
    chk(sr_viol == 0, "R5", {tag, " access during sr_req"}, 64'(sr_viol), 64'h0);
    chk(last_gap == ((dly == 0) ? 1 : dly) + 2, "R4", {tag, " retention idle gap"}, 64'(last_gap),
        64'(((dly == 0) ? 1 : dly) + 2));
    chk(fail == 1'b0, "R9", {tag, " fail on clean memory"}, 64'(fail), 64'h0);
    chk(n_done == 1 && !busy && !done, "R12", {tag, " single done pulse"}, 64'(n_done), 64'h1);
  endtask

  task automatic run_all();
    void'($urandom(32'h5eed1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !fail && !sr_req && !mem_we && !mem_re, "R12", "reset outputs",
        64'({busy, done, fail, sr_req, mem_we, mem_re}), 64'h0);
    @(posedge clk); #5 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !sr_req && !mem_we && !mem_re, "R12", "idle after reset",
        64'({busy, done, fail, sr_req, mem_we, mem_re}), 64'h0);

    // directed: no twists, self-refresh kept, extra start while busy (R2, R12)
    set_cfg(0, 0, 0, 0);
    skip_p1_sr = 1'b0; delay_cycles = 20'd6;
    build_trace();
    run_bist(1'b1);
    check_clean("R2 row/col walk", 6, 4);

    // directed: twists on, phase-0 self-refresh skipped (R6)
    set_cfg(3, 6, 1, 1);
    skip_p1_sr = 1'b1; delay_cycles = 20'd1;
    build_trace();
    run_bist(1'b0);
    check_clean("R6 skip", 1, 2);

    // corner: zero retention length (R4)
    set_cfg(0, 5, 1, 0);
    skip_p1_sr = 1'b0; delay_cycles = 20'd0;
    build_trace();
    run_bist(1'b0);
    check_clean("R4 zero delay", 0, 4);

    // random configurations (R7, R8)
    for (int t = 0; t < 4; t++) begin
      int d = 1 + $urandom % 30;
      set_cfg($urandom % 8, $urandom % 8, $urandom % 2, $urandom % 2);
      skip_p1_sr = 1'($urandom % 2); delay_cycles = 20'(d);
      build_trace();
      run_bist(1'b0);
      check_clean("R7 random", d, skip_p1_sr ? 2 : 4);
    end

    // fault, keep running (R10, R11)
    begin
      int first = -1;
      set_cfg(2, 4, 1, 1);
      skip_p1_sr = 1'b0; delay_cycles = 20'd3;
      build_trace();
      flt_addr = 5'($urandom % NW);
      flt_mask = 32'h1 << ($urandom % 32);
      flt_on = 1'b1;
      for (int i = 0; i < n_exp; i++) if (first < 0 && !tr_we[i] && tr_addr[i] == flt_addr) first = i;
      run_bist(1'b0);
      chk(fail == 1'b1, "R10", "fail set by fault", 64'(fail), 64'h1);
      chk(diag_phase == 1'(tr_ph[first]) && diag_elem == 4'(tr_el[first]), "R10", "diag phase/step",
          64'({diag_phase, diag_elem}), 64'({1'(tr_ph[first]), 4'(tr_el[first])}));
      chk(diag_addr == flt_addr, "R10", "diag address", 64'(diag_addr), 64'(flt_addr));
      chk(diag_exp == tr_data[first], "R10", "diag expected", 64'(diag_exp), 64'(tr_data[first]));
      chk(diag_act == (tr_data[first] ^ flt_mask), "R10", "diag actual", 64'(diag_act),
          64'(tr_data[first] ^ flt_mask));
      chk(mon_i == n_exp && trace_err == 0, "R11", "no stop runs to end", 64'(mon_i), 64'(n_exp));

      // fault with stop-on-fail (R11)
      stop_on_fail = 1'b1;
      run_bist(1'b0);
      chk(n_done == 1 && mon_i < n_exp && mon_i > first, "R11", "halt shortens run",
          64'(mon_i), 64'(first + 2));
      chk(late_acc == 0, "R11", "no access after halt", 64'(late_acc), 64'h0);
      chk(fail == 1'b1 && diag_addr == flt_addr, "R10", "diag after halt", 64'(diag_addr), 64'(flt_addr));

      // new start clears the sticky flag (R10)
      flt_on = 1'b0;
      stop_on_fail = 1'b0;
      run_bist(1'b0);
      chk(fail == 1'b0 && trace_err == 0, "R10", "fail cleared by next run", 64'(fail), 64'h0);
    end
  endtask

  bit wd_fired = 1'b0;
  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) chk(1'b0, "R12", "watchdog expired", 64'h1, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule